// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives two-channel serial audio as a slave. A bit clock, a word-select line and a serial data line come in from an external transmitter. The block oversamples all three with its own system clock and resynchronises them. It then takes each bit on the rising edge of the bit clock and rebuilds one left and one right sample per frame. A two-bit format input chooses between delayed MSB-first framing (I2S) and right-aligned framing with 16, 20 or 24 bit words.

Each completed stereo pair appears on two parallel output words, together with a single-cycle valid strobe. In the right-aligned modes the word sits against the word-select transition. The block therefore counts the bit slots in every half-frame, and it flags a half-frame that is too short to hold the selected word. Format changes are held back until the start of the next left channel, so a frame is never decoded in two formats.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and after its release, before any frame has completed, `left_o` and `right_o` are zero and `valid_o` and `err_o` are low.
- R2: `fmt_i` is decoded as 00 = I2S, 01 = right-aligned 16 bit, 10 = right-aligned 20 bit, 11 = right-aligned 24 bit. It is captured only at the bit clock rise where word select is first seen low. A change in the middle of a frame does not affect that frame's right word.
- R3: In I2S mode, word select low marks the left channel. The MSB is sampled one bit clock after the word-select transition, and later bits fill the output MSB first. Output bits whose slots the half-frame never reached read as zero.
- R4: In I2S mode, bits in slots after the 24th of a half-frame have no effect on the output word.
- R5: In right-aligned 16-bit mode, the 16 bits sampled just before the word-select transition form the word, LSB last. The word appears in output bits 23:8, and bits 7:0 are zero.
- R6: In right-aligned 20-bit mode, the last 20 bits before the transition appear in output bits 23:4, and bits 3:0 are zero.
- R7: In right-aligned 24-bit mode, the last 24 bits before the transition fill the output. This includes a half-frame of exactly 24 slots.
- R8: In a right-aligned mode, `err_o` pulses for one cycle for each half-frame with fewer bit slots than the word length. I2S mode never raises `err_o`.
- R9: `valid_o` pulses for exactly one cycle after each right word completes, once per left/right pair. It presents that frame's left and right words.
- R10: In I2S mode, when a half-frame has exactly 24 slots, the word's LSB is taken from the first slot after the next word-select transition.
- R11: Half-frames seen before the first complete left half-frame after reset produce neither `valid_o` nor `err_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word select, low = left channel |
| sd_i | input | 1 | Serial data |
| fmt_i | input | 2 | Framing select (see R2) |
| left_o | output | SAMPLE_W | Left sample of the last pair |
| right_o | output | SAMPLE_W | Right sample of the last pair |
| valid_o | output | 1 | One-cycle strobe per stereo pair |
| err_o | output | 1 | One-cycle framing-error pulse |

## Verification
The bench targets the slot boundaries. One case is an I2S half-frame of exactly 24 slots, whose LSB arrives after the word-select edge; a design that drops that bit yields a zero LSB. Another is a right-aligned half-frame of exactly the word length, whose MSB sits in the boundary slot; an off-by-one design shifts the word by one bit. Short right-aligned half-frames must raise the error pulse, while short I2S ones must only truncate. A format change inside the left half-frame must not re-decode the right word, or its value would come out misplaced. Junk bits beyond slot 24 and a partial frame after reset catch designs that keep extra bits or strobe too early.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

   typedef enum logic [1:0] {
      FMT_I2S  = 2'b00,
      FMT_RJ16 = 2'b01,
      FMT_RJ20 = 2'b10,
      FMT_RJ24 = 2'b11
   } rx_fmt_e;

   // word length of a right-aligned framing
   function automatic int rj_len(rx_fmt_e f);
      case (f)
         FMT_RJ16: return 16;
         FMT_RJ20: return 20;
         default:  return 24;
      endcase
   endfunction

endpackage

// File: rtl/serial_audio_rx_sync.sv
module serial_audio_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bck_i,
   input  logic ws_i,
   input  logic sd_i,
   output logic rise_o,
   output logic ws_o,
   output logic sd_o
);

   logic bck_s;
   logic bck_d;

   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("serial_audio_rx_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_direct
         assign bck_s = bck_i;
         assign ws_o  = ws_i;
         assign sd_o  = sd_i;
      end else begin : g_chain
         logic [STAGES-1:0] bck_q;
         logic [STAGES-1:0] ws_q;
         logic [STAGES-1:0] sd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bck_q <= '0;
               ws_q  <= '0;
               sd_q  <= '0;
            end else begin
               bck_q[0] <= bck_i;
               ws_q[0]  <= ws_i;
               sd_q[0]  <= sd_i;
               for (int i = 1; i < STAGES; i++) begin
                  bck_q[i] <= bck_q[i-1];
                  ws_q[i]  <= ws_q[i-1];
                  sd_q[i]  <= sd_q[i-1];
               end
            end
         end
         assign bck_s = bck_q[STAGES-1];
         assign ws_o  = ws_q[STAGES-1];
         assign sd_o  = sd_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bck_d <= 1'b0;
      else        bck_d <= bck_s;
   end

   assign rise_o = bck_s & ~bck_d;

   // R3
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/serial_audio_rx_slots.sv
module serial_audio_rx_slots #(
   parameter int SLOT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_i,
   input  logic              ws_i,
   output logic              bnd_o,
   output logic              ws_old_o,
   output logic [SLOT_W-1:0] idx_o
);

   localparam logic [SLOT_W-1:0] CNT_TOP = '1;

   logic              seen;
   logic              ws_q;
   logic [SLOT_W-1:0] cnt;

   // a rise whose word select differs from the previous rise opens a half-frame
   assign bnd_o    = rise_i & seen & (ws_i ^ ws_q);
   assign ws_old_o = ws_q;
   assign idx_o    = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen <= 1'b0;
         ws_q <= 1'b0;
         cnt  <= '0;
      end else if (rise_i) begin
         seen <= 1'b1;
         ws_q <= ws_i;
         if (bnd_o)                cnt <= SLOT_W'(1);
         else if (cnt != CNT_TOP)  cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/serial_audio_rx_word.sv
module serial_audio_rx_word
   import serial_audio_rx_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int SLOT_W   = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rise_i,
   input  logic                bnd_i,
   input  logic [SLOT_W-1:0]   idx_i,
   input  logic                sd_i,
   input  rx_fmt_e             fmt_i,
   output logic [SAMPLE_W-1:0] word_o,
   output logic                short_o
);

   localparam logic [SAMPLE_W-1:0] ONES = '1;

   logic [SAMPLE_W-1:0] sr;
   logic [SAMPLE_W-1:0] acc;
   logic [SAMPLE_W-1:0] place;
   logic [SAMPLE_W-1:0] rj_word;
   int                  rj_n;

   // delayed MSB-first: slot k (k >= 1) lands in bit SAMPLE_W-k
   always_comb begin
      place = '0;
      for (int b = 0; b < SAMPLE_W; b++) begin
         if (int'(idx_i) == SAMPLE_W - b) place[b] = sd_i;
      end
   end

   // right-aligned: last rj_n bits, moved to the top
   always_comb begin
      rj_n    = rj_len(fmt_i);
      rj_word = (sr & ~(ONES << rj_n)) << (SAMPLE_W - rj_n);
   end

   assign word_o  = (fmt_i == FMT_I2S) ? (acc | place) : rj_word;
   assign short_o = (fmt_i != FMT_I2S) && (int'(idx_i) < rj_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr  <= '0;
         acc <= '0;
      end else if (rise_i) begin
         sr  <= {sr[SAMPLE_W-2:0], sd_i};
         acc <= bnd_i ? '0 : (acc | place);
      end
   end

   // R3
   acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i && bnd_i) |=> (acc == '0));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import serial_audio_rx_pkg::*;
#(
   parameter int SAMPLE_W    = 24,
   parameter int MAX_SLOTS   = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bck_i,
   input  logic                ws_i,
   input  logic                sd_i,
   input  logic [1:0]          fmt_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o,
   output logic                err_o
);

   localparam int SLOT_W = $clog2(MAX_SLOTS) + 1;

   generate
      if (SAMPLE_W < 24) begin : g_bad_width
         $error("serial_audio_rx: SAMPLE_W must be at least 24");
      end
      if (MAX_SLOTS < 24) begin : g_bad_slots
         $error("serial_audio_rx: MAX_SLOTS must be at least 24");
      end
   endgenerate

   logic                rise;
   logic                ws_s;
   logic                sd_s;
   logic                bnd;
   logic                ws_old;
   logic [SLOT_W-1:0]   idx;
   logic [SAMPLE_W-1:0] word;
   logic                short_hf;

   rx_fmt_e             fmt_act;
   logic                started;
   logic                have_left;
   logic [SAMPLE_W-1:0] left_hold;

   serial_audio_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .bck_i(bck_i), .ws_i(ws_i), .sd_i(sd_i),
      .rise_o(rise), .ws_o(ws_s), .sd_o(sd_s)
   );

   serial_audio_rx_slots #(.SLOT_W(SLOT_W)) u_slots (
      .clk(clk), .rst_n(rst_n), .rise_i(rise), .ws_i(ws_s),
      .bnd_o(bnd), .ws_old_o(ws_old), .idx_o(idx)
   );

   serial_audio_rx_word #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_word (
      .clk(clk), .rst_n(rst_n), .rise_i(rise), .bnd_i(bnd), .idx_i(idx),
      .sd_i(sd_s), .fmt_i(fmt_act), .word_o(word), .short_o(short_hf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_act   <= FMT_I2S;
         started   <= 1'b0;
         have_left <= 1'b0;
         left_hold <= '0;
         left_o    <= '0;
         right_o   <= '0;
         valid_o   <= 1'b0;
         err_o     <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         err_o   <= 1'b0;
         if (bnd) begin
            started <= 1'b1;
            if (started) begin
               err_o <= short_hf;
               if (!ws_old) begin
                  left_hold <= word;
                  have_left <= 1'b1;
               end else if (have_left) begin
                  left_o    <= left_hold;
                  right_o   <= word;
                  valid_o   <= 1'b1;
                  have_left <= 1'b0;
               end
            end
            if (!ws_s) fmt_act <= rx_fmt_e'(fmt_i);
         end
      end
   end

   // R9
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R9
   valid_after_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(bnd && ws_old));

   // R2
   fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bnd && !ws_s) |=> $stable(fmt_act));

   // R8
   err_rj_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> ($past(fmt_act) != FMT_I2S));

endmodule

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bck_i, ws_i, sd_i;
   logic [1:0]  fmt_i;
   logic [23:0] left_o, right_o;
   logic        valid_o, err_o;

   always #2 clk = ~clk;

   serial_audio_rx dut (
      .clk(clk), .rst_n(rst_n), .bck_i(bck_i), .ws_i(ws_i), .sd_i(sd_i),
      .fmt_i(fmt_i), .left_o(left_o), .right_o(right_o),
      .valid_o(valid_o), .err_o(err_o)
   );

   int errors = 0;
   int checks = 0;
   int err_seen = 0;
   int err_exp = 0;
   bit done = 0;

   logic [23:0] q_l[$];
   logic [23:0] q_r[$];
   bit          q_chk[$];
   string       q_tag[$];

   logic carry = 1'b0;
   bit   prev_i2s = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // monitor: compare each strobe with the next expected pair
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         if (err_o) err_seen++;
         if (valid_o) begin
            if (q_l.size() == 0) begin
               check(0, "R9/R11", "unexpected strobe", 32'd1, 32'd0);
            end else begin
               logic [23:0] el, er;
               bit          ec;
               string       et;
               el = q_l.pop_front();
               er = q_r.pop_front();
               ec = q_chk.pop_front();
               et = q_tag.pop_front();
               if (ec) begin
                  check(left_o == el, et, "left", left_o, el);
                  check(right_o == er, et, "right", right_o, er);
               end
            end
         end
      end
   end

   function automatic int flen(input int f);
      return (f == 1) ? 16 : (f == 2) ? 20 : 24;
   endfunction

   // bit that a transmitter places in slot j of a half-frame of H slots
   function automatic logic gen(input int f, input int h, input logic [23:0] w, input int j);
      if (f == 0) begin
         if (j >= 1 && j <= 24) return w[24-j];
         return 1'($urandom_range(0, 1));
      end else begin
         int k;
         k = h - 1 - j;
         if (j < h && k >= 0 && k < flen(f)) return w[k];
         return 1'($urandom_range(0, 1));
      end
   endfunction

   function automatic logic [23:0] expw(input int f, input int h, input logic [23:0] w);
      if (f == 0) begin
         if (h >= 24) return w;
         return w & ~((24'h1 << (24 - h)) - 24'h1);
      end else begin
         int n;
         n = flen(f);
         return (w & ((24'h1 << n) - 24'h1)) << (24 - n);
      end
   endfunction

   task automatic slot(input logic w, input logic d);
      @(negedge clk);
      bck_i = 1'b0;
      ws_i  = w;
      sd_i  = d;
      repeat (4) @(negedge clk);
      bck_i = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic half(input logic w, input int f, input int h, input logic [23:0] word,
                       input bit chg, input int nf);
      logic b0;
      b0 = prev_i2s ? carry : gen(f, h, word, 0);
      slot(w, b0);
      for (int j = 1; j < h; j++) begin
         if (chg && j == 3) fmt_i = nf[1:0];
         slot(w, gen(f, h, word, j));
      end
      carry    = gen(f, h, word, h);
      prev_i2s = (f == 0);
   endtask

   task automatic frame(input int f, input int h, input logic [23:0] lw, input logic [23:0] rw,
                        input string tag, input bit chg, input int nf);
      bit sh;
      fmt_i = f[1:0];
      sh = (f != 0) && (h < flen(f));
      q_l.push_back(expw(f, h, lw));
      q_r.push_back(expw(f, h, rw));
      q_chk.push_back(!sh);
      q_tag.push_back(tag);
      if (sh) err_exp += 2;
      half(1'b0, f, h, lw, chg, nf);
      half(1'b1, f, h, rw, 1'b0, 0);
   endtask

   function automatic logic [23:0] rnd24();
      return 24'($urandom);
   endfunction

   function automatic logic [23:0] pad(input logic [23:0] w, input int l);
      return w & (24'hFFFFFF << (24 - l));
   endfunction

   initial begin
      void'($urandom(32'd20251));
      rst_n = 1'b0;
      bck_i = 1'b0;
      ws_i  = 1'b0;
      sd_i  = 1'b0;
      fmt_i = 2'b00;
      repeat (6) @(negedge clk);
      check(left_o == 24'd0 && right_o == 24'd0, "R1", "outputs in reset", {left_o, 8'd0} | right_o, 32'd0);
      check(valid_o == 1'b0 && err_o == 1'b0, "R1", "strobes in reset", {valid_o, err_o}, 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(left_o == 24'd0 && right_o == 24'd0 && !valid_o && !err_o, "R1",
            "outputs after reset", {valid_o, err_o}, 32'd0);

      // R11: partial left then partial right before the first real frame
      for (int j = 0; j < 5; j++) slot(1'b0, 1'($urandom_range(0, 1)));
      for (int j = 0; j < 7; j++) slot(1'b1, 1'($urandom_range(0, 1)));
      check(err_seen == 0, "R11", "error pulses before first frame", err_seen, 0);

      // directed corners
      frame(0, 32, rnd24(), rnd24(), "R3", 0, 0);
      frame(0, 32, pad(rnd24(), 16), pad(rnd24(), 16), "R3", 0, 0);
      frame(0, 30, pad(rnd24(), 20), rnd24(), "R4", 0, 0);
      frame(0, 24, rnd24(), rnd24(), "R10", 0, 0);
      frame(0, 20, rnd24(), rnd24(), "R3", 0, 0);
      frame(1, 32, rnd24(), rnd24(), "R5", 0, 0);
      frame(1, 16, rnd24(), rnd24(), "R5", 0, 0);
      frame(2, 24, rnd24(), rnd24(), "R6", 0, 0);
      frame(2, 20, rnd24(), rnd24(), "R6", 0, 0);
      frame(3, 32, rnd24(), rnd24(), "R7", 0, 0);
      frame(3, 24, rnd24(), rnd24(), "R7", 0, 0);
      frame(2, 17, rnd24(), rnd24(), "R8", 0, 0);
      check(err_seen == 1, "R8", "error pulses after first short half", err_seen, 1);
      frame(1, 18, rnd24(), rnd24(), "R8", 0, 0);
      frame(3, 32, rnd24(), rnd24(), "R2", 1, 0);
      frame(0, 32, rnd24(), rnd24(), "R2", 0, 0);
      frame(1, 32, rnd24(), rnd24(), "R2", 1, 3);
      frame(3, 28, rnd24(), rnd24(), "R2", 0, 0);

      // random frames
      for (int n = 0; n < 40; n++) begin
         int f, h;
         f = $urandom_range(0, 3);
         if (f == 0) begin
            int l;
            l = ($urandom_range(0, 2) == 0) ? 16 : 24;
            h = $urandom_range(24, 32);
            frame(0, h, pad(rnd24(), l), pad(rnd24(), l), "R9", 0, 0);
         end else begin
            if ($urandom_range(0, 7) == 0) h = flen(f) - $urandom_range(1, 4);
            else h = $urandom_range(flen(f) + 1, 32);
            frame(f, h, rnd24(), rnd24(), "R9", 0, 0);
         end
      end

      // flush the last pair with the next left-channel start
      for (int j = 0; j < 3; j++) slot(1'b0, 1'b0);
      repeat (20) @(negedge clk);
      check(q_l.size() == 0, "R9", "pairs still expected", q_l.size(), 0);
      check(err_seen == err_exp, "R8", "error pulse count", err_seen, err_exp);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule